// File: doc/BRIEF.md
# Trigger-Less Strip Hit Capture Core

This core collects discriminator hits from 128 detector strips without any trigger. The strips form 16 independent sets of 8 channels. An 8-bit beam-crossing counter runs freely in the crossing clock domain. Each low-to-high transition on a strip input is taken as a hit. The strip is marked pending in its set, and the counter value at that edge is kept with it. A hit that comes back on a strip that is still pending is dropped, and a sticky overflow flag for that set is raised.

Pending hits go to a downstream formatter over a valid/ready handshake, one record per transfer. A rotating arbiter chooses the set. Inside the chosen set, the lowest-numbered pending strip goes first. Records are therefore not in time order, and each record carries its own crossing stamp.

A global enable gates delivery to the output. A reject control blocks new hits from being accepted. A store strobe copies the running crossing count into a register that can be read at the ports.

Top module: `hit_capture_core`

## Requirements
- R1: After reset, `outValid` is 0, `storedCount` is 0, `overflowFlags` is all zero, no strip is pending, and the crossing counter is 0.
- R2: The crossing counter is 8 bits wide. It increments on every clock edge after reset and wraps from 255 to 0. A record's `outStamp` is the counter value at the edge that sampled the strip's rising input.
- R3: A hit is a low-to-high transition of `hitIn[i]` between two sampled edges. An input held high yields exactly one record.
- R4: A rising input sampled while `rejectHits` is 1 is discarded. It creates no pending entry and sets no overflow flag.
- R5: `outValid` is 1 only when `sendData` is 1 and at least one strip is pending. While `sendData` is 0, no record is delivered.
- R6: Within the set being offered, the pending strip with the lowest index is offered first.
- R7: Sets are chosen in rotating order, starting from the set after the most recently transferred one. After reset, set 0 has first priority. A set is served again only after every other set with pending hits has transferred one record.
- R8: A rising input on a strip that is already pending is dropped, and its stamp is kept. The drop sets `overflowFlags[s]`, where s is the set number, and the flag stays set until reset. If the strip is transferred on the same edge, the new hit is accepted instead.
- R9: While `outValid` is 1 and `outReady` is 0, and `sendData` stays 1, the next cycle offers the same `outSet`, `outStrip` and `outStamp`, even if other hits arrive.
- R10: On an edge where `storeCount` is 1, `storedCount` takes the current counter value. Otherwise `storedCount` holds.
- R11: Strip input `hitIn[s*8+k]` is reported with `outSet` = s (0..15) and `outStrip` = k (0..7). A transfer occurs on an edge where both `outValid` and `outReady` are 1, and it clears that strip's pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitIn | input | 128 | Discriminator outputs, bit s*8+k is strip k of set s |
| rejectHits | input | 1 | Discard new hits while high |
| sendData | input | 1 | Enable delivery of records |
| storeCount | input | 1 | Copy crossing counter into storedCount |
| outReady | input | 1 | Formatter accepts the offered record |
| outValid | output | 1 | A record is offered |
| outStrip | output | 3 | Strip index within set |
| outSet | output | 5 | Set number |
| outStamp | output | 8 | Crossing number of the hit |
| storedCount | output | 8 | Last stored crossing count |
| overflowFlags | output | 16 | Sticky per-set drop flags |

## Verification
The bench targets a strip that is retriggered on the same edge on which it is transferred. A design that checks the pending bit before the transfer clears it would drop that hit and raise a false overflow. It also stalls the handshake while a hit arrives in a set with higher rotating priority; a design without a locked selection would switch the offered record in the middle of the stall. Further cases are a strip held high for many cycles, which a level-sensitive design would report again and again, and a stretch of toggling under reject, which a design that gates only acceptance and not overflow would flag. Crossing-counter wraparound and the rotating order after each transfer are checked every cycle against a behavioural model.

// File: rtl/hitcap_pkg.sv
package hitcap_pkg;
  localparam int NumSets  = 16;
  localparam int SetChans = 8;
  localparam int StampW   = 8;
  localparam int SetW     = $clog2(NumSets);
  localparam int ChanW    = $clog2(SetChans);
  localparam int NumChans = NumSets * SetChans;

  // strobes from control to datapath
  typedef struct packed {
    logic             offer;
    logic             take;
    logic [SetW-1:0]  selSet;
    logic [ChanW-1:0] selChan;
  } selStrobe_t;
endpackage

// File: rtl/hit_set.sv
module hit_set
  import hitcap_pkg::*;
#(
  parameter int Chans     = SetChans,
  parameter int StampBits = StampW
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [Chans-1:0]           riseIn,
  input  logic [StampBits-1:0]       stampNow,
  input  logic [Chans-1:0]           takeMask,
  output logic [Chans-1:0]           pendMask,
  output logic [Chans*StampBits-1:0] stampFlat,
  output logic                       ovfFlag
);
  logic [Chans-1:0] keptPend;
  logic [Chans-1:0] acceptMask;
  logic [Chans-1:0] dropMask;

  always_comb begin
    keptPend   = pendMask & ~takeMask;
    acceptMask = riseIn & ~keptPend;
    dropMask   = riseIn & keptPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      pendMask <= keptPend | riseIn;
      ovfFlag  <= ovfFlag | (|dropMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampFlat <= '0;
    end else begin
      for (int c = 0; c < Chans; c++) begin
        if (acceptMask[c]) stampFlat[c*StampBits +: StampBits] <= stampNow;
      end
    end
  end
endmodule

// File: rtl/hit_dp.sv
module hit_dp
  import hitcap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumChans-1:0] hitIn,
  input  logic                rejectHits,
  input  logic                storeCount,
  input  selStrobe_t          strobe,
  output logic [NumChans-1:0] pendAll,
  output logic [StampW-1:0]   selStamp,
  output logic [StampW-1:0]   storedCount,
  output logic [NumSets-1:0]  ovfAll
);
  logic [NumChans-1:0]        prevHit;
  logic [NumChans-1:0]        riseAll;
  logic [NumChans-1:0]        takeAll;
  logic [StampW-1:0]          crossCount;
  logic [NumChans*StampW-1:0] stampAll;
  int                         selIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHit     <= '0;
      crossCount  <= '0;
      storedCount <= '0;
    end else begin
      prevHit    <= hitIn;
      crossCount <= crossCount + 1'b1;
      if (storeCount) storedCount <= crossCount;
    end
  end

  always_comb begin
    riseAll = hitIn & ~prevHit & {NumChans{~rejectHits}};
    selIdx  = int'(strobe.selSet) * SetChans + int'(strobe.selChan);
    takeAll = '0;
    if (strobe.take) takeAll[selIdx] = 1'b1;
    selStamp = stampAll[selIdx*StampW +: StampW];
  end

  for (genvar s = 0; s < NumSets; s++) begin : g_set
    hit_set #(.Chans(SetChans), .StampBits(StampW)) set_i (
      .clk      (clk),
      .rstN     (rstN),
      .riseIn   (riseAll[s*SetChans +: SetChans]),
      .stampNow (crossCount),
      .takeMask (takeAll[s*SetChans +: SetChans]),
      .pendMask (pendAll[s*SetChans +: SetChans]),
      .stampFlat(stampAll[s*SetChans*StampW +: SetChans*StampW]),
      .ovfFlag  (ovfAll[s])
    );
  end
endmodule

// File: rtl/hit_ctl.sv
module hit_ctl
  import hitcap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumChans-1:0] pendAll,
  input  logic                sendData,
  input  logic                outReady,
  output selStrobe_t          strobe,
  output logic                outValid,
  output logic [SetW-1:0]     outSet,
  output logic [ChanW-1:0]    outStrip
);
  logic [NumSets-1:0]  setAny;
  logic [SetW-1:0]     lastGrant;
  logic                lockActive;
  logic [SetW-1:0]     lockSet;
  logic [ChanW-1:0]    lockChan;
  logic                rrFound;
  logic [SetW-1:0]     rrSet;
  logic [ChanW-1:0]    rrChan;
  logic [SetChans-1:0] rrMask;
  logic [SetW-1:0]     pickSet;
  logic [ChanW-1:0]    pickChan;
  logic                offer;
  logic                take;

  for (genvar s = 0; s < NumSets; s++) begin : g_any
    assign setAny[s] = |pendAll[s*SetChans +: SetChans];
  end

  // rotating search starting after the last served set
  always_comb begin
    rrFound = 1'b0;
    rrSet   = '0;
    for (int k = 1; k <= NumSets; k++) begin
      if (!rrFound && setAny[(int'(lastGrant) + k) % NumSets]) begin
        rrFound = 1'b1;
        rrSet   = SetW'((int'(lastGrant) + k) % NumSets);
      end
    end
    rrMask = pendAll[int'(rrSet)*SetChans +: SetChans];
    rrChan = '0;
    for (int c = SetChans - 1; c >= 0; c--) begin
      if (rrMask[c]) rrChan = ChanW'(c);
    end
  end

  always_comb begin
    pickSet  = lockActive ? lockSet  : rrSet;
    pickChan = lockActive ? lockChan : rrChan;
    offer    = sendData & (lockActive | rrFound);
    take     = offer & outReady;
    strobe.offer   = offer;
    strobe.take    = take;
    strobe.selSet  = pickSet;
    strobe.selChan = pickChan;
    outValid = offer;
    outSet   = pickSet;
    outStrip = pickChan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastGrant  <= SetW'(NumSets - 1);
      lockActive <= 1'b0;
      lockSet    <= '0;
      lockChan   <= '0;
    end else begin
      lockActive <= offer & ~outReady;
      if (offer) begin
        lockSet  <= pickSet;
        lockChan <= pickChan;
      end
      if (take) lastGrant <= pickSet;
    end
  end
endmodule

// File: rtl/hit_capture_core.sv
module hit_capture_core
  import hitcap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumChans-1:0] hitIn,
  input  logic                rejectHits,
  input  logic                sendData,
  input  logic                storeCount,
  input  logic                outReady,
  output logic                outValid,
  output logic [ChanW-1:0]    outStrip,
  output logic [SetW:0]       outSet,
  output logic [StampW-1:0]   outStamp,
  output logic [StampW-1:0]   storedCount,
  output logic [NumSets-1:0]  overflowFlags
);
  selStrobe_t          strobe;
  logic [NumChans-1:0] pendAll;
  logic [SetW-1:0]     setIdx;

  hit_ctl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .pendAll (pendAll),
    .sendData(sendData),
    .outReady(outReady),
    .strobe  (strobe),
    .outValid(outValid),
    .outSet  (setIdx),
    .outStrip(outStrip)
  );

  hit_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .hitIn      (hitIn),
    .rejectHits (rejectHits),
    .storeCount (storeCount),
    .strobe     (strobe),
    .pendAll    (pendAll),
    .selStamp   (outStamp),
    .storedCount(storedCount),
    .ovfAll     (overflowFlags)
  );

  // record set field is one bit wider than the set index
  assign outSet = {1'b0, setIdx};
endmodule

// File: rtl/hit_capture_core_chk.sv
module hit_capture_core_chk
  import hitcap_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                rejectHits,
  input logic                sendData,
  input logic                storeCount,
  input logic                outReady,
  input logic                outValid,
  input logic [ChanW-1:0]    outStrip,
  input logic [SetW:0]       outSet,
  input logic [StampW-1:0]   outStamp,
  input logic [StampW-1:0]   storedCount,
  input logic [NumSets-1:0]  overflowFlags
);
  // R5
  send_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> sendData);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (!sendData ||
      (outValid && $stable(outSet) && $stable(outStrip) && $stable(outStamp))));

  // R4
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectHits |=> $stable(overflowFlags));

  // R10
  store_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !storeCount |=> $stable(storedCount));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlags != '0) |=> ((~overflowFlags & $past(overflowFlags)) == '0));
endmodule

bind hit_capture_core hit_capture_core_chk chk_i (.*);

// File: tb/hit_capture_core_tb.sv
`timescale 1ns/1ps
module hit_capture_core_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] hitIn = '0;
  logic         rejectHits = 1'b0;
  logic         sendData = 1'b0;
  logic         storeCount = 1'b0;
  logic         outReady = 1'b0;
  logic         outValid;
  logic [2:0]   outStrip;
  logic [4:0]   outSet;
  logic [7:0]   outStamp;
  logic [7:0]   storedCount;
  logic [15:0]  overflowFlags;

  int checks = 0;
  int errors = 0;
  int fires  = 0;

  // behavioural reference state
  bit mPend[128];
  int mStamp[128];
  bit mPrev[128];
  bit mOvf[16];
  int mCnt, mStored, mLast, mLockSet, mLockChan;
  bit mLock;
  bit expValid;
  int expSet, expChan, expStamp;

  always #2.5 clk = ~clk;

  hit_capture_core dut_i (.*);

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < 128; i++) begin
      mPend[i] = 0; mStamp[i] = 0; mPrev[i] = 0;
    end
    for (int s = 0; s < 16; s++) mOvf[s] = 0;
    mCnt = 0; mStored = 0; mLast = 15; mLock = 0; mLockSet = 0; mLockChan = 0;
  endfunction

  function automatic bit setHas(input int s);
    for (int k = 0; k < 8; k++) if (mPend[s*8+k]) return 1;
    return 0;
  endfunction

  function automatic void modelEval();
    bit found;
    expValid = 0; expSet = 0; expChan = 0; expStamp = 0;
    found = 0;
    if (mLock) begin
      found = 1; expSet = mLockSet; expChan = mLockChan;
    end else begin
      for (int k = 1; k <= 16; k++) begin
        if (!found && setHas((mLast + k) % 16)) begin
          found = 1; expSet = (mLast + k) % 16;
        end
      end
      if (found) begin
        for (int c = 7; c >= 0; c--) if (mPend[expSet*8+c]) expChan = c;
      end
    end
    expValid = sendData && found;
    expStamp = mStamp[expSet*8+expChan];
  endfunction

  function automatic void modelStep();
    bit fire;
    fire = expValid && outReady;
    if (fire) begin
      mPend[expSet*8+expChan] = 0;
      mLast = expSet;
      fires++;
    end
    for (int i = 0; i < 128; i++) begin
      if (hitIn[i] && !mPrev[i] && !rejectHits) begin
        if (mPend[i]) mOvf[i/8] = 1;
        else begin mPend[i] = 1; mStamp[i] = mCnt; end
      end
      mPrev[i] = hitIn[i];
    end
    if (storeCount) mStored = mCnt;
    mCnt = (mCnt + 1) % 256;
    mLock = expValid && !outReady;
    if (expValid) begin mLockSet = expSet; mLockChan = expChan; end
  endfunction

  task automatic compareAll();
    int ovfExp;
    ovfExp = 0;
    for (int s = 0; s < 16; s++) if (mOvf[s]) ovfExp |= (1 << s);
    chk(int'(outValid), int'(expValid), "R5", "outValid");
    if (expValid) begin
      chk(int'(outSet), expSet, "R7", "outSet");
      chk(int'(outStrip), expChan, "R6", "outStrip");
      chk(int'(outStamp), expStamp, "R2", "outStamp");
    end
    chk(int'(overflowFlags), ovfExp, "R8", "overflowFlags");
    chk(int'(storedCount), mStored, "R10", "storedCount");
  endtask

  task automatic step();
    #1;
    modelEval();
    compareAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic drain();
    sendData = 1; outReady = 1;
    repeat (40) step();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, c0, t0;
    int ovfBefore;
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1;
    sendData = 1;
    #1;
    // R1 reset state
    chk(int'(outValid), 0, "R1", "outValid after reset");
    chk(int'(storedCount), 0, "R1", "storedCount after reset");
    chk(int'(overflowFlags), 0, "R1", "overflowFlags after reset");
    sendData = 0;
    repeat (3) step();

    // R11 strip 110 -> set 13 strip 6; R9 stall with competing hit
    hitIn[110] = 1; step(); hitIn[110] = 0; step();
    sendData = 1; outReady = 0; step();
    chk(int'(outValid), 1, "R11", "valid for strip 110");
    chk(int'(outSet), 13, "R11", "set of strip 110");
    chk(int'(outStrip), 6, "R11", "strip of strip 110");
    s0 = outSet; c0 = outStrip; t0 = outStamp;
    hitIn[16] = 1; step(); hitIn[16] = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(int'(outSet), s0, "R9", "stalled set");
      chk(int'(outStrip), c0, "R9", "stalled strip");
      chk(int'(outStamp), t0, "R9", "stalled stamp");
    end
    drain();

    // R3 held input yields a single record
    sendData = 0; outReady = 0; fires = 0;
    hitIn[5] = 1; repeat (10) step();
    drain();
    hitIn[5] = 0; step();
    chk(fires, 1, "R3", "records from held input");

    // R4 toggles under reject
    sendData = 0; outReady = 0; rejectHits = 1; fires = 0;
    ovfBefore = overflowFlags;
    for (int r = 0; r < 6; r++) begin
      hitIn[20:0] = (r % 2 == 0) ? '1 : '0; step();
    end
    hitIn = '0; step();
    rejectHits = 0; drain();
    chk(fires, 0, "R4", "records after rejected hits");
    chk(int'(overflowFlags), ovfBefore, "R4", "overflow after rejected hits");

    // R8 repeat hit on pending strip
    sendData = 0;
    hitIn[3] = 1; step(); hitIn[3] = 0; step();
    hitIn[3] = 1; step(); hitIn[3] = 0; step();
    chk(int'(overflowFlags[0]), 1, "R8", "overflow set 0");
    drain();

    // R6/R7 several sets and strips at once
    sendData = 0;
    hitIn[7] = 1; hitIn[1] = 1; hitIn[33] = 1; hitIn[34] = 1; hitIn[127] = 1; hitIn[64] = 1;
    step(); hitIn = '0; step();
    drain();

    // random traffic, counter wraps many times
    for (int n = 0; n < 5000; n++) begin
      for (int i = 0; i < 128; i++) hitIn[i] = ($urandom % 30 == 0);
      rejectHits = ($urandom % 12 == 0);
      sendData   = ($urandom % 6 != 0);
      outReady   = ($urandom % 3 != 0);
      storeCount = ($urandom % 20 == 0);
      step();
    end
    hitIn = '0; rejectHits = 0; storeCount = 0;
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule